// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block owns the refresh work of an asynchronous fast page mode DRAM array. After reset it waits out a long power-up delay, then runs a fixed burst of refresh cycles before it raises `mem_ready`. From then on it keeps a free-running interval counter. Each time the counter expires it adds one refresh to a small backlog. While the backlog is non-zero it raises `rfsh_req` to the access arbiter.

When the arbiter answers with `rfsh_gnt`, the block drives a CAS-before-RAS cycle: CAS low first, then every RAS strobe low together, then a full precharge with all strobes high. It pulses `rfsh_done` in the last precharge cycle and then hands the strobes back. WE is held high throughout, so a refresh can never be taken for a test-mode entry.

All analog minima are given in nanoseconds and turned into clock counts by rounding up. The system clock period is also a parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `mem_ready`, `rfsh_req` and `rfsh_done` are 0, and every RAS line, `cas_n` and `we_n` are 1.
- R2: `mem_ready` rises exactly ceil(STARTUP_NS/CLK_NS) + INIT_CYCLES*(setup+active+precharge) clock cycles after reset is released, and stays high afterwards.
- R3: Before `mem_ready` the block performs exactly INIT_CYCLES refresh pulses without any grant, and `rfsh_req` stays 0.
- R4: CAS is low for at least ceil(5 ns) cycles before RAS falls, and CAS stays low for the whole RAS-low pulse.
- R5: Every RAS-low pulse lasts exactly max(ceil(60 ns), ceil(10 ns)) cycles, and all RAS lines (active low) fall and rise together.
- R6: Between two refresh pulses RAS stays high for at least precharge+setup cycles, and CAS is high for at least ceil(max(40 ns, 10 ns)) cycles before it falls again.
- R7: `we_n` is 1 whenever RAS falls and at every other time.
- R8: The first `rfsh_req` appears exactly ceil(REF_INTERVAL_NS/CLK_NS) cycles after `mem_ready` rises, and one refresh is owed every such interval from then on.
- R9: Intervals that expire while the grant is withheld are queued, and each one is served once the grant arrives.
- R10: The backlog saturates at PEND_MAX; refreshes owed beyond it are dropped.
- R11: After `mem_ready`, the strobes stay high while no grant is given. `strobe_own` is high from grant to completion. `rfsh_done` is a single-cycle pulse per completed granted refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_gnt | input | 1 | Arbiter grants the strobes for a refresh |
| rfsh_req | output | 1 | A refresh is owed and the block is idle |
| rfsh_done | output | 1 | One-cycle pulse in the last precharge cycle |
| mem_ready | output | 1 | Power-up sequence complete, access allowed |
| strobe_own | output | 1 | Block is driving the strobes |
| ras_n | output | BANKS | RAS strobes, active low, driven together |
| cas_n | output | 1 | CAS strobe, active low |
| we_n | output | 1 | WE strobe, held high |

## Verification
The power-up path is run with the grant tied low, which separates the ungranted initialization burst from granted refreshes and fixes the exact cycle of `mem_ready`. Periodic refreshes are then tried in two patterns. In the first, the grant is withheld for three intervals, which shows that the backlog is kept. In the second, it is withheld for six intervals, which shows the saturation limit. Every RAS pulse in all phases is measured for CAS setup, pulse width, bank alignment, precharge gap and WE level, against a queue of expected pulses.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_IDLE,
        ST_SETUP,
        ST_ACT,
        ST_PRE
    } rfsh_state_e;

    // strobe levels, active low as driven on the pins
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_rfsh_interval.sv
module dram_rfsh_interval #(
    parameter int IVL      = 1953,
    parameter int PEND_MAX = 4,
    localparam int IVL_W   = $clog2(IVL),
    localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              served,
    output logic              pend_nz,
    output logic [PEND_W-1:0] pend_cnt
);

    logic [IVL_W-1:0] ivl_cnt;
    logic             tick;

    assign tick = run && (ivl_cnt == IVL_W'(IVL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_cnt <= '0;
        end else if (run) begin
            ivl_cnt <= tick ? '0 : ivl_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cnt <= '0;
        end else begin
            case ({tick, served})
                2'b10: if (pend_cnt != PEND_W'(PEND_MAX)) pend_cnt <= pend_cnt + 1'b1;
                2'b01: pend_cnt <= pend_cnt - 1'b1;
                default: pend_cnt <= pend_cnt;
            endcase
        end
    end

    assign pend_nz = (pend_cnt != '0);

endmodule

// File: rtl/dram_rfsh_fsm.sv
module dram_rfsh_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int T_START     = 25000,
    parameter int T_SETUP     = 1,
    parameter int T_ACT       = 8,
    parameter int T_PRE       = 5,
    parameter int INIT_CYCLES = 8,
    localparam int TMR_W      = $clog2(max2(max2(T_START, T_ACT), max2(T_PRE, T_SETUP)) + 1),
    localparam int INIT_W     = $clog2(INIT_CYCLES + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pend_nz,
    input  logic    gnt,
    output logic    ready,
    output logic    req,
    output logic    done,
    output logic    own,
    output strobe_t strb
);

    rfsh_state_e       state;
    logic [TMR_W-1:0]  tmr;
    logic [INIT_W-1:0] init_cnt;
    logic              tmr_end;

    assign tmr_end = (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_WAIT;
            tmr      <= TMR_W'(T_START - 1);
            init_cnt <= '0;
            ready    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pend_nz && gnt) begin
                        state <= ST_SETUP;
                        tmr   <= TMR_W'(T_SETUP - 1);
                    end
                end
                default: begin
                    if (!tmr_end) begin
                        tmr <= tmr - 1'b1;
                    end else if (state == ST_WAIT) begin
                        state <= ST_SETUP;
                        tmr   <= TMR_W'(T_SETUP - 1);
                    end else if (state == ST_SETUP) begin
                        state <= ST_ACT;
                        tmr   <= TMR_W'(T_ACT - 1);
                    end else if (state == ST_ACT) begin
                        state <= ST_PRE;
                        tmr   <= TMR_W'(T_PRE - 1);
                    end else if (ready) begin
                        state <= ST_IDLE;
                    end else if (init_cnt == INIT_W'(INIT_CYCLES - 1)) begin
                        ready <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        init_cnt <= init_cnt + 1'b1;
                        state    <= ST_SETUP;
                        tmr      <= TMR_W'(T_SETUP - 1);
                    end
                end
            endcase
        end
    end

    assign req  = ready && (state == ST_IDLE) && pend_nz;
    assign done = ready && (state == ST_PRE) && tmr_end;
    assign own  = !ready || (state != ST_IDLE);

    always_comb begin
        strb.ras_n = (state != ST_ACT);
        strb.cas_n = !((state == ST_SETUP) || (state == ST_ACT));
        strb.we_n  = 1'b1;
    end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_NS          = 8,
    parameter int STARTUP_NS      = 200000,
    parameter int INIT_CYCLES     = 8,
    parameter int REF_INTERVAL_NS = 15625,
    parameter int CAS_SETUP_NS    = 5,
    parameter int CAS_HOLD_NS     = 10,
    parameter int RAS_LOW_NS      = 60,
    parameter int RAS_PRE_NS      = 40,
    parameter int CAS_PRE_NS      = 10,
    parameter int PEND_MAX        = 4,
    parameter int BANKS           = 2,
    localparam int T_START = ns_to_cycles(STARTUP_NS, CLK_NS),
    localparam int T_IVL   = ns_to_cycles(REF_INTERVAL_NS, CLK_NS),
    localparam int T_SETUP = ns_to_cycles(CAS_SETUP_NS, CLK_NS),
    localparam int T_ACT   = max2(ns_to_cycles(RAS_LOW_NS, CLK_NS), ns_to_cycles(CAS_HOLD_NS, CLK_NS)),
    localparam int T_PRE   = max2(ns_to_cycles(RAS_PRE_NS, CLK_NS), ns_to_cycles(CAS_PRE_NS, CLK_NS)),
    localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rfsh_gnt,
    output logic             rfsh_req,
    output logic             rfsh_done,
    output logic             mem_ready,
    output logic             strobe_own,
    output logic [BANKS-1:0] ras_n,
    output logic             cas_n,
    output logic             we_n
);

    logic              pend_nz;
    logic [PEND_W-1:0] pend_cnt;
    strobe_t           strb;

    dram_rfsh_interval #(
        .IVL      (T_IVL),
        .PEND_MAX (PEND_MAX)
    ) u_ivl (
        .clk      (clk),
        .rst      (rst),
        .run      (mem_ready),
        .served   (rfsh_done),
        .pend_nz  (pend_nz),
        .pend_cnt (pend_cnt)
    );

    dram_rfsh_fsm #(
        .T_START     (T_START),
        .T_SETUP     (T_SETUP),
        .T_ACT       (T_ACT),
        .T_PRE       (T_PRE),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pend_nz (pend_nz),
        .gnt     (rfsh_gnt),
        .ready   (mem_ready),
        .req     (rfsh_req),
        .done    (rfsh_done),
        .own     (strobe_own),
        .strb    (strb)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_ras
        assign ras_n[b] = strb.ras_n;
    end

    assign cas_n = strb.cas_n;
    assign we_n  = strb.we_n;

endmodule

// File: rtl/dram_rfsh_checker.sv
module dram_rfsh_checker #(
    parameter int PEND_MAX = 4,
    parameter int BANKS    = 2,
    localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_ready,
    input logic              rfsh_req,
    input logic              rfsh_gnt,
    input logic              rfsh_done,
    input logic              strobe_own,
    input logic [BANKS-1:0]  ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [PEND_W-1:0] pend_cnt
);

    // R3
    no_req_before_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ready |-> !rfsh_req);

    // R4
    cas_before_ras_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n[0]) |-> (!cas_n && $past(!cas_n)));

    // R4
    cas_low_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_n[0] |-> !cas_n);

    // R7
    we_high_at_ras_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n[0]) |-> (we_n && $past(we_n)));

    // R10
    backlog_limit_chk: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= PEND_W'(PEND_MAX));

    // R11
    no_grant_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (rfsh_req && !rfsh_gnt) |=> (cas_n && (&ras_n)));

    // R11
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rfsh_done |=> !rfsh_done);

    // R11
    own_during_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> strobe_own);

endmodule

bind dram_refresh_seq dram_rfsh_checker #(
    .PEND_MAX (PEND_MAX),
    .BANKS    (BANKS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_ready  (mem_ready),
    .rfsh_req   (rfsh_req),
    .rfsh_gnt   (rfsh_gnt),
    .rfsh_done  (rfsh_done),
    .strobe_own (strobe_own),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .pend_cnt   (pend_cnt)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

    localparam int BANKS   = 2;
    localparam int T_START = 100;  // 800 ns at 8 ns
    localparam int T_IVL   = 125;  // 1000 ns at 8 ns
    localparam int T_SETUP = 1;
    localparam int T_ACT   = 8;
    localparam int T_PRE   = 5;
    localparam int INITS   = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rfsh_gnt = 1'b0;
    logic             rfsh_req, rfsh_done, mem_ready, strobe_own, cas_n, we_n;
    logic [BANKS-1:0] ras_n;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dram_refresh_seq #(
        .CLK_NS          (8),
        .STARTUP_NS      (800),
        .INIT_CYCLES     (INITS),
        .REF_INTERVAL_NS (1000),
        .PEND_MAX        (4),
        .BANKS           (BANKS)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .rfsh_gnt   (rfsh_gnt),
        .rfsh_req   (rfsh_req),
        .rfsh_done  (rfsh_done),
        .mem_ready  (mem_ready),
        .strobe_own (strobe_own),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver side: announce refresh pulses the monitor must see
    task automatic expect_pulses(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(T_ACT);
    endtask

    // monitor: checks every RAS pulse against the queue
    int  low_len = 0, high_len = 0, cas_high = 0;
    bit  had_pulse = 1'b0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (ras_n[0] != ras_n[1]) check(0, "R5 banks", ras_n, {BANKS{ras_n[0]}});
            if (!we_n) check(0, "R7 we_n", we_n, 1);
            if (!mem_ready && rfsh_req) check(0, "R3 req before ready", 1, 0);
            if (!prev_ras && ras_n[0]) begin
                int e;
                if (exp_q.size() == 0) begin
                    check(0, "R11 unexpected pulse", low_len, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(low_len == e, "R5 width", low_len, e);
                end
                had_pulse = 1'b1;
                high_len = 0;
            end
            if (prev_ras && !ras_n[0]) begin
                check(!prev_cas && !cas_n, "R4 cas setup", prev_cas, 0);
                check(we_n, "R7 we at ras fall", we_n, 1);
                if (had_pulse)
                    check(high_len >= T_PRE + T_SETUP, "R6 ras gap", high_len, T_PRE + T_SETUP);
                low_len = 0;
            end
            if (prev_cas && !cas_n && had_pulse)
                check(cas_high >= T_PRE, "R6 cas precharge", cas_high, T_PRE);
            if (!ras_n[0]) begin
                low_len++;
                if (cas_n) check(0, "R4 cas in pulse", cas_n, 0);
                if (!strobe_own) check(0, "R11 own", strobe_own, 1);
            end else high_len++;
            cas_high = cas_n ? cas_high + 1 : 0;
            prev_ras = ras_n[0];
            prev_cas = cas_n;
        end
    end

    task automatic serve(input int n, input string req);
        int cnt = 0;
        expect_pulses(n);
        rfsh_gnt = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); @(negedge clk);
            if (rfsh_done) cnt++;
            if (cnt > 0 && !rfsh_req && !strobe_own) break;
        end
        rfsh_gnt = 1'b0;
        check(cnt == n, req, cnt, n);
        check(!strobe_own && cas_n, "R11 handback", strobe_own, 0);
    endtask

    task automatic hold_off(input int cyc);
        int lows = 0;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk); @(negedge clk);
            if (!ras_n[0] || !cas_n || rfsh_done) lows++;
        end
        check(lows == 0, "R11 no strobe without grant", lows, 0);
        check(rfsh_req, "R9 request held", rfsh_req, 1);
    endtask

    initial begin
        int n;
        expect_pulses(INITS);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!mem_ready && !rfsh_req && !rfsh_done, "R1 reset outputs", mem_ready, 0);
        check(&ras_n && cas_n && we_n, "R1 reset strobes", {ras_n, cas_n, we_n}, 4'hf);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!mem_ready && &ras_n && cas_n && we_n, "R1 after release", mem_ready, 0);
        n = 1;
        while (!mem_ready && n < 1000) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
        check(n == T_START + INITS * (T_SETUP + T_ACT + T_PRE), "R2 ready cycle",
              n, T_START + INITS * (T_SETUP + T_ACT + T_PRE));
        check(exp_q.size() == 0, "R3 init pulses", INITS - exp_q.size(), INITS);
        n = 0;
        while (!rfsh_req && n < 1000) begin
            @(posedge clk); @(negedge clk);
            n++;
            if (!mem_ready) check(0, "R2 ready stays", 0, 1);
        end
        check(n == T_IVL, "R8 first request", n, T_IVL);
        hold_off(2 * T_IVL + 60);
        serve(3, "R9 backlog of three");
        hold_off(680);
        serve(4, "R10 saturated backlog");
        n = 0;
        while (!rfsh_req && n < 400) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
        check(rfsh_req && mem_ready, "R8 periodic request", rfsh_req, 1);
        serve(1, "R8 single refresh");
        check(exp_q.size() == 0, "R5 all pulses seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule